// File: doc/BRIEF.md
# Erased-Sector ECC Verdict Checker

This block sits behind a hardware ECC engine on a flash read path and turns the engine's one-byte status into a final verdict for a 2048-byte sector. A start pulse loads the 8-byte status slot. One byte of that slot holds the status, and a parameter chooses which byte. When the engine reports a clean or corrected sector, the block answers at once with the engine's corrected-bit count and never asks for sector data.

When the engine reports an uncorrectable sector, the block does not simply accept that result. A freshly erased page reads as all ones, and it has no valid check bytes, so the engine flags it as a failure. To catch this case, the block pulls the sector in as 512 words of 32 bits over a valid/ready handshake. It counts the zero bits in those words and compares the count against the engine's 6-bit count field, which serves as a threshold.

If the zero count stays within the threshold, the sector is declared erased: the verdict is success, the corrected count is zero, and a fill flag tells downstream logic to replace the sector with 0xFF bytes. If the count goes past the threshold, the verdict is uncorrectable. Once the threshold is passed, the block adds no more words to the count, but it still consumes the rest of the sector so the word stream stays aligned.

Top module: `ecc_verdict`

## Requirements
- R1: The status byte is taken from byte 4 (bits 39:32) of `statusSlot` when `BIG_ENDIAN_SLOT` is 0, and from byte 7 (bits 63:56) when it is 1. The other bytes of the slot have no effect.
- R2: If bit 7 of the status byte is clear, `done` pulses without any word being requested. `wordReady` stays low throughout, and `uncorrectable` is 0, `fillOnes` is 0 and `corrCount` equals status bits 5:0.
- R3: If bit 7 is set, `wordReady` goes high and exactly 512 words are accepted, one on each cycle where both `wordValid` and `wordReady` are high. `zeroCount` accumulates the number of zero bits in each accepted word and never decreases during the sector.
- R4: Once `zeroCount` exceeds the threshold (status bits 5:0), later words are still accepted but add nothing, so `zeroCount` holds the value it had at that point.
- R5: If the final `zeroCount` is greater than the threshold, then at `done`: `uncorrectable` is 1, `fillOnes` is 0 and `corrCount` is 0.
- R6: If the final `zeroCount` is at most the threshold, then at `done`: `uncorrectable` is 0, `fillOnes` is 1 and `corrCount` is 0. This includes the boundary where the count equals the threshold.
- R7: `done` is high for exactly one cycle. The verdict outputs keep their values after it until the next accepted start.
- R8: A synchronous active-high `rst` returns the block to idle within one clock. After that clock, `done`, `wordReady`, `uncorrectable`, `fillOnes`, `corrCount` and `zeroCount` are all 0.
- R9: A `start` pulse that arrives while a sector is being counted is ignored. It does not change the verdict of the sector in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a check; loads the status byte from the slot |
| statusSlot | input | 64 | 8-byte status slot from the ECC engine |
| wordValid | input | 1 | Sector word on `wordData` is valid |
| wordData | input | 32 | Sector data word |
| wordReady | output | 1 | Block is accepting sector words |
| done | output | 1 | One-cycle pulse; verdict outputs valid |
| uncorrectable | output | 1 | Sector could not be recovered |
| corrCount | output | 6 | Corrected-bit count reported with the verdict |
| fillOnes | output | 1 | Sector is erased; replace all bytes with 0xFF |
| zeroCount | output | 14 | Zero bits counted in the sector (saturating) |

## Verification
The block is tried with clean status bytes whose other slot bytes carry the opposite flag. This shows whether the correct byte is chosen and whether the data stream is left untouched. Failed status bytes are paired with all-ones sectors, with sectors holding exactly the threshold number of zeros and with sectors holding one zero more, which separates the erased verdict from the uncorrectable one at the boundary. A sector with a fully zero word followed by more zeros shows whether the count freezes once the threshold is passed. Random sparse and dense sectors, random handshake gaps, a start pulse during counting and a reset in mid-sector check the ordering behaviour.

// File: rtl/ecc_verdict_pkg.sv
package ecc_verdict_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DECIDE = 2'd1,
    ST_COUNT  = 2'd2,
    ST_FINAL  = 2'd3
  } state_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic latchStatus;  // load status byte, clear counter and verdict
    logic accumulate;   // a sector word is accepted this cycle
    logic finishClean;  // verdict straight from the status byte
    logic finishCount;  // verdict from the zero-bit count
  } strobe_t;

endpackage

// File: rtl/ecc_verdict_ctrl.sv
module ecc_verdict_ctrl
  import ecc_verdict_pkg::*;
#(
  parameter int WORDS = 512
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  logic    wordValid,
  input  logic    statusFail,
  output logic    wordReady,
  output strobe_t strobe
);

  localparam int WCNT_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [WCNT_W-1:0] LAST_WORD = WCNT_W'(WORDS - 1);

  state_e state, stateNext;
  logic [WCNT_W-1:0] wordCnt;
  logic accept;
  logic lastWord;

  assign wordReady = (state == ST_COUNT);
  assign accept    = wordReady && wordValid;
  assign lastWord  = (wordCnt == LAST_WORD);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (start) stateNext = ST_DECIDE;
      ST_DECIDE: stateNext = statusFail ? ST_COUNT : ST_IDLE;
      ST_COUNT:  if (accept && lastWord) stateNext = ST_FINAL;
      ST_FINAL:  stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe             = '0;
    strobe.latchStatus = (state == ST_IDLE) && start;
    strobe.accumulate  = accept;
    strobe.finishClean = (state == ST_DECIDE) && !statusFail;
    strobe.finishCount = (state == ST_FINAL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      wordCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_DECIDE) begin
        wordCnt <= '0;
      end else if (accept) begin
        wordCnt <= wordCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ecc_verdict_dp.sv
module ecc_verdict_dp
  import ecc_verdict_pkg::*;
#(
  parameter int  SLOT_BYTES      = 8,
  parameter bit  BIG_ENDIAN_SLOT = 1'b0,
  parameter int  WORD_W          = 32,
  parameter int  ACC_W           = 14,
  parameter int  CNT_W           = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  strobe_t                 strobe,
  input  logic [8*SLOT_BYTES-1:0] statusSlot,
  input  logic [WORD_W-1:0]       wordData,
  output logic                    statusFail,
  output logic [7:0]              statusByte,
  output logic                    done,
  output logic                    uncorrectable,
  output logic [CNT_W-1:0]        corrCount,
  output logic                    fillOnes,
  output logic [ACC_W-1:0]        zeroCount
);

  localparam int PC_W    = $clog2(WORD_W + 1);
  localparam int LE_OFS  = 4;
  localparam int BE_OFS  = SLOT_BYTES - 1;

  logic [7:0]        slotByte;
  logic [PC_W-1:0]   wordZeros;
  logic [ACC_W:0]    accSum;
  logic [ACC_W-1:0]  threshold;
  logic              overThr;

  generate
    if (BIG_ENDIAN_SLOT) begin : g_be
      assign slotByte = statusSlot[8*BE_OFS +: 8];
    end else begin : g_le
      assign slotByte = statusSlot[8*LE_OFS +: 8];
    end
  endgenerate

  // Zero bits of the incoming word
  always_comb begin
    wordZeros = '0;
    for (int b = 0; b < WORD_W; b++) begin
      wordZeros = wordZeros + PC_W'(!wordData[b]);
    end
  end

  assign threshold  = ACC_W'(statusByte[CNT_W-1:0]);
  assign overThr    = zeroCount > threshold;
  assign accSum     = {1'b0, zeroCount} + (ACC_W+1)'(wordZeros);
  assign statusFail = statusByte[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      statusByte    <= '0;
      zeroCount     <= '0;
      done          <= 1'b0;
      uncorrectable <= 1'b0;
      corrCount     <= '0;
      fillOnes      <= 1'b0;
    end else begin
      done <= strobe.finishClean || strobe.finishCount;
      if (strobe.latchStatus) begin
        statusByte    <= slotByte;
        zeroCount     <= '0;
        uncorrectable <= 1'b0;
        corrCount     <= '0;
        fillOnes      <= 1'b0;
      end
      if (strobe.accumulate && !overThr) begin
        zeroCount <= accSum[ACC_W] ? {ACC_W{1'b1}} : accSum[ACC_W-1:0];
      end
      if (strobe.finishClean) begin
        uncorrectable <= 1'b0;
        corrCount     <= statusByte[CNT_W-1:0];
        fillOnes      <= 1'b0;
      end
      if (strobe.finishCount) begin
        uncorrectable <= overThr;
        corrCount     <= '0;
        fillOnes      <= !overThr;
      end
    end
  end

endmodule

// File: rtl/ecc_verdict.sv
module ecc_verdict
  import ecc_verdict_pkg::*;
#(
  parameter int SLOT_BYTES      = 8,
  parameter bit BIG_ENDIAN_SLOT = 1'b0,
  parameter int WORD_W          = 32,
  parameter int SECTOR_BYTES    = 2048,
  parameter int ACC_W           = 14,
  parameter int CNT_W           = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [8*SLOT_BYTES-1:0] statusSlot,
  input  logic                    wordValid,
  input  logic [WORD_W-1:0]       wordData,
  output logic                    wordReady,
  output logic                    done,
  output logic                    uncorrectable,
  output logic [CNT_W-1:0]        corrCount,
  output logic                    fillOnes,
  output logic [ACC_W-1:0]        zeroCount
);

  localparam int WORDS = SECTOR_BYTES / (WORD_W / 8);

  strobe_t    strobe;
  logic       statusFail;
  logic [7:0] statusByte;

  ecc_verdict_ctrl #(
    .WORDS(WORDS)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .wordValid (wordValid),
    .statusFail(statusFail),
    .wordReady (wordReady),
    .strobe    (strobe)
  );

  ecc_verdict_dp #(
    .SLOT_BYTES     (SLOT_BYTES),
    .BIG_ENDIAN_SLOT(BIG_ENDIAN_SLOT),
    .WORD_W         (WORD_W),
    .ACC_W          (ACC_W),
    .CNT_W          (CNT_W)
  ) u_dp (
    .clk          (clk),
    .rst          (rst),
    .strobe       (strobe),
    .statusSlot   (statusSlot),
    .wordData     (wordData),
    .statusFail   (statusFail),
    .statusByte   (statusByte),
    .done         (done),
    .uncorrectable(uncorrectable),
    .corrCount    (corrCount),
    .fillOnes     (fillOnes),
    .zeroCount    (zeroCount)
  );

endmodule

// File: rtl/ecc_verdict_chk.sv
module ecc_verdict_chk #(
  parameter int ACC_W = 14,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             wordReady,
  input logic             done,
  input logic             uncorrectable,
  input logic [CNT_W-1:0] corrCount,
  input logic             fillOnes,
  input logic [ACC_W-1:0] zeroCount,
  input logic [7:0]       statusByte
);

  logic [ACC_W-1:0] thr;
  assign thr = ACC_W'(statusByte[CNT_W-1:0]);

  // R8: reset leaves the block idle with no verdict pending
  p_reset_idle_r8: assert property (@(posedge clk)
    rst |=> (!done && !wordReady && zeroCount == '0));

  // R7: done is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2: no word is requested for a clean status byte
  p_clean_no_ready_r2: assert property (@(posedge clk) disable iff (rst)
    !statusByte[7] |-> !wordReady);

  // R2: the clean verdict carries the status count
  p_clean_verdict_r2: assert property (@(posedge clk) disable iff (rst)
    (done && !statusByte[7]) |-> (!uncorrectable && !fillOnes && corrCount == statusByte[CNT_W-1:0]));

  // R3: the zero count never falls while words are taken
  p_count_mono_r3: assert property (@(posedge clk) disable iff (rst)
    wordReady |=> (zeroCount >= $past(zeroCount)));

  // R4: the count is frozen once past the threshold
  p_count_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    (wordReady && zeroCount > thr) |=> $stable(zeroCount));

  // R5: uncorrectable verdict agrees with the count
  p_uncorr_r5: assert property (@(posedge clk) disable iff (rst)
    (done && statusByte[7]) |-> (uncorrectable == (zeroCount > thr)));

  // R6: erased verdict fills with ones and reports no corrections
  p_erased_r6: assert property (@(posedge clk) disable iff (rst)
    (done && fillOnes) |-> (!uncorrectable && corrCount == '0 && zeroCount <= thr));

endmodule

bind ecc_verdict ecc_verdict_chk #(
  .ACC_W(ACC_W),
  .CNT_W(CNT_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .wordReady    (wordReady),
  .done         (done),
  .uncorrectable(uncorrectable),
  .corrCount    (corrCount),
  .fillOnes     (fillOnes),
  .zeroCount    (zeroCount),
  .statusByte   (statusByte)
);

// File: tb/ecc_verdict_tb.sv
module ecc_verdict_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WORDS      = 512;
  localparam int SAT_MAX    = 16383;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [63:0] statusSlot = '0;
  logic        wordValid = 1'b0;
  logic [31:0] wordData = '0;
  logic        wordReady;
  logic        done;
  logic        uncorrectable;
  logic [5:0]  corrCount;
  logic        fillOnes;
  logic [13:0] zeroCount;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [31:0] words [WORDS];

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_verdict u_dut (
    .clk(clk), .rst(rst), .start(start), .statusSlot(statusSlot),
    .wordValid(wordValid), .wordData(wordData), .wordReady(wordReady),
    .done(done), .uncorrectable(uncorrectable), .corrCount(corrCount),
    .fillOnes(fillOnes), .zeroCount(zeroCount)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WATCHDOG) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input int actual, input int expected, input string tag);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  function automatic logic [63:0] makeSlot(input logic [7:0] stat);
    logic [63:0] s;
    for (int k = 0; k < 8; k++) s[8*k +: 8] = stat ^ 8'hA5 ^ 8'(k);
    s[39:32] = stat;   // little-endian slot offset (R1)
    return s;
  endfunction

  task automatic fillAllOnes();
    for (int k = 0; k < WORDS; k++) words[k] = 32'hFFFF_FFFF;
  endtask

  task automatic injectZeros(input int n);
    for (int k = 0; k < n; k++) begin
      int pos;
      pos = $urandom % (WORDS * 32);
      words[pos / 32][pos % 32] = 1'b0;
    end
  endtask

  task automatic injectExact(input int n);
    // n distinct zero bits spread over the sector
    for (int k = 0; k < n; k++) words[(k * 37) % WORDS][k % 32] = 1'b0;
  endtask

  task automatic expectOf(input logic [7:0] stat, output int eZero,
                          output int eUnc, output int eFill, output int eCorr);
    int acc;
    int thr;
    thr = int'(stat[5:0]);
    if (!stat[7]) begin
      eZero = 0; eUnc = 0; eFill = 0; eCorr = int'(stat[5:0]);
    end else begin
      acc = 0;
      for (int k = 0; k < WORDS; k++) begin
        if (acc <= thr) acc = acc + $countones(~words[k]);
      end
      if (acc > SAT_MAX) acc = SAT_MAX;
      eZero = acc;
      eUnc  = (acc > thr) ? 1 : 0;
      eFill = (acc > thr) ? 0 : 1;
      eCorr = 0;
    end
  endtask

  task automatic waitDone(output bit seen, output bit sawReady);
    seen = 0;
    sawReady = 0;
    for (int k = 0; k < 40 && !seen; k++) begin
      @(negedge clk);
      if (wordReady) sawReady = 1;
      if (done) seen = 1;
    end
  endtask

  // One sector check; busyAt >= 0 raises start during counting (R9)
  task automatic runOp(input logic [7:0] stat, input int busyAt, input string tag);
    int eZero, eUnc, eFill, eCorr;
    bit seen, sawReady;
    int idx;
    int heldUnc, heldFill, heldCorr;
    expectOf(stat, eZero, eUnc, eFill, eCorr);
    @(negedge clk);
    statusSlot = makeSlot(stat);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!stat[7]) begin
      wordValid = 1'b1;            // junk must be ignored (R2)
      wordData  = 32'h0;
      waitDone(seen, sawReady);
      wordValid = 1'b0;
      chk(int'(sawReady), 0, {tag, " R2 wordReady stays low"});
    end else begin
      idx = 0;
      while (idx < WORDS && cycles < WATCHDOG) begin
        @(negedge clk);
        start = (busyAt >= 0 && idx == busyAt) ? 1'b1 : 1'b0;
        if (start) statusSlot = makeSlot(8'h00);
        if (wordReady && ($urandom % 4 != 0)) begin
          wordValid = 1'b1;
          wordData  = words[idx];
          idx++;
        end else begin
          wordValid = 1'b0;
          wordData  = 32'h0;
        end
      end
      @(negedge clk);
      start = 1'b0;
      wordValid = 1'b0;
      chk(int'(wordReady), 0, {tag, " R3 no word after 512"});
      waitDone(seen, sawReady);
      chk(int'(sawReady), 0, {tag, " R3 exactly 512 words"});
    end
    chk(int'(seen), 1, {tag, " R7 done seen"});
    chk(int'(uncorrectable), eUnc, {tag, " R5 uncorrectable"});
    chk(int'(fillOnes), eFill, {tag, " R6 fillOnes"});
    chk(int'(corrCount), eCorr, {tag, " R2 corrCount"});
    chk(int'(zeroCount), eZero, {tag, " R4 zeroCount"});
    heldUnc = int'(uncorrectable); heldFill = int'(fillOnes); heldCorr = int'(corrCount);
    @(negedge clk);
    chk(int'(done), 0, {tag, " R7 done one cycle"});
    chk(int'(uncorrectable) * 4 + int'(fillOnes) * 2 + int'(corrCount == 6'(heldCorr)),
        heldUnc * 4 + heldFill * 2 + 1, {tag, " R7 verdict held"});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(int'(done), 0, "R8 reset done");
    chk(int'(wordReady), 0, "R8 reset wordReady");
    chk(int'(zeroCount), 0, "R8 reset zeroCount");
    chk(int'(uncorrectable) + int'(fillOnes) + int'(corrCount), 0, "R8 reset verdict");
    rst = 1'b0;

    // R2 / R1: clean status with opposite flag in other slot bytes
    fillAllOnes();
    runOp(8'h05, -1, "clean05");
    runOp(8'h3F, -1, "clean3f R1");
    runOp(8'h40, -1, "clean40 R1");

    // R6: all-ones sector with zero threshold
    fillAllOnes();
    runOp(8'h80, -1, "erased thr0");
    // R6 boundary: exactly threshold zeros
    fillAllOnes(); injectExact(10);
    runOp(8'h8A, -1, "erased eq thr");
    // R5 boundary: one zero above threshold
    fillAllOnes(); injectExact(11);
    runOp(8'h8A, -1, "uncorr thr+1");
    // R4: full-zero word trips early, later zeros not counted
    fillAllOnes(); words[5] = 32'h0; words[300] = 32'h0000_FFFF;
    runOp(8'h83, -1, "early stop R4");
    // R3: dense random data
    for (int k = 0; k < WORDS; k++) words[k] = $urandom;
    runOp(8'hBF, -1, "random dense R3");
    // R9: start during counting is ignored
    fillAllOnes(); injectExact(7);
    runOp(8'h87, 100, "busy start R9");

    // Random mix
    for (int t = 0; t < 16; t++) begin
      logic [7:0] st;
      st = 8'($urandom);
      fillAllOnes();
      injectZeros($urandom % (2 * int'(st[5:0]) + 6));
      runOp(st, -1, "random mix");
    end

    // R8: reset in mid-sector
    fillAllOnes(); injectExact(3);
    @(negedge clk);
    statusSlot = makeSlot(8'h90);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      wordValid = 1'b1;
      wordData  = 32'h0;
    end
    rst = 1'b1;
    wordValid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    chk(int'(wordReady), 0, "R8 mid reset wordReady");
    chk(int'(zeroCount), 0, "R8 mid reset zeroCount");
    chk(int'(done) + int'(uncorrectable) + int'(fillOnes), 0, "R8 mid reset verdict");
    runOp(8'h90, -1, "after reset");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule